// File: doc/BRIEF.md
# Fixed-Point System Time Counter

This block keeps a 64-bit system time register that advances on every cycle of its reference clock by a programmable fixed-point increment, rather than by one nanosecond per tick. The increment carries a large binary scale factor, so software can trim the clock rate finely by rewriting the increment. The nanosecond count is recovered with a right shift alone. The shift amount follows the link-speed input, because the reference clock period is 6.4 ns at the 10G rate or with no link, 64 ns at 1G, and 640 ns at 100M.

Software reaches the counter through a 32-bit register port with four word addresses: time low, time high, increment, and a read-only shift status. Reading the low word captures the high word so that the 64-bit pair stays consistent. Writing the low word and then the high word loads the whole time in one step. The raw time and its nanosecond value are driven out to the clock-output and timestamp-capture logic.

A parameter selects the wide variant, with a 31-bit increment, or the narrow variant, with a 24-bit increment, an enable bit at bit 24 that software must set to 1, and shifts reduced by 7.

Top module: `ptp_sys_time`

## Requirements
- R1: While reset is held, `time_o` and `rdata_o` are zero. After reset the increment register reads 0x66666666 in the wide variant and 0x01CCCCCC in the narrow variant.
- R2: On every clock edge with no time-high write, `time_o` grows by the active increment field, modulo 2^64. The field is bits [30:0] in the wide variant and bits [23:0] in the narrow variant.
- R3: A write to address 2 stores only the increment field. In the narrow variant bit 24 is stored as well. All other bits read back as 0. The new value governs the edges after the write edge, and the write leaves `time_o` untouched.
- R4: In the narrow variant, when bit 24 of the increment register is 0, `time_o` holds its value.
- R5: A read returns data one cycle after `rd_en_i`, and `rdata_o` holds that data until the next read. Address 0 returns bits [31:0] of the time seen in the issue cycle and captures bits [63:32] into a shadow. Address 1 returns the shadow, address 2 returns the increment register, and address 3 returns the shift in bits [4:0].
- R6: A write to address 0 only stages a word, and time keeps running. A write to address 1 makes `time_o` equal {written word, staged word} on the next cycle, in place of that edge's increment.
- R7: `shift_o` is 28 for link code 0 (10G) or 3 (no link), 24 for code 1 (1G) and 21 for code 2 (100M). The narrow variant uses 7 less. `ns_o` equals `time_o` shifted right by `shift_o`.
- R8: A write to address 3 has no effect on time, increment or staged data.
- R9: Time wraps from values near 2^64 through zero without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; one tick per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Word address: 0 time low, 1 time high, 2 increment, 3 shift status |
| wdata_i | input | 32 | Write data |
| link_spd_i | input | 2 | Link speed code: 0 10G, 1 1G, 2 100M, 3 no link |
| rdata_o | output | 32 | Read data, registered |
| time_o | output | 64 | Raw fixed-point system time |
| ns_o | output | 64 | Time in nanoseconds |
| shift_o | output | 5 | Active nanosecond shift |

## Verification
The assertions assume that the strobes and address are known in every cycle after reset, and that a time-high write follows a time-low write whenever a meaningful load is wanted. Otherwise the load uses the word last staged. The bench changes inputs only at the falling edge, never raises a read and a write in the same cycle, and holds the link code steady while it checks a status read. It drives both variants from one stimulus stream, so the masking, enable-bit and shift-offset differences can be seen side by side.

// File: rtl/ptp_sys_pkg.sv
package ptp_sys_pkg;
  typedef enum logic [1:0] {
    SPD_10G  = 2'd0,
    SPD_1G   = 2'd1,
    SPD_100M = 2'd2,
    SPD_NONE = 2'd3
  } link_spd_e;

  typedef enum logic [1:0] {
    REG_TLO  = 2'd0,
    REG_THI  = 2'd1,
    REG_INC  = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  localparam int unsigned SHIFT_W      = 5;
  localparam int unsigned NARROW_ADJ   = 7;
  localparam logic [31:0] INC_BASE_10G = 32'h6666_6666;

  function automatic logic [SHIFT_W-1:0] base_shift(input logic [1:0] spd);
    case (spd)
      SPD_1G:   base_shift = 5'd24;
      SPD_100M: base_shift = 5'd21;
      default:  base_shift = 5'd28;
    endcase
  endfunction
endpackage

// File: rtl/ptp_sys_accum.sv
module ptp_sys_accum
  import ptp_sys_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter bit          NARROW = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [2*REG_W-1:0] load_val_i,
  input  logic               inc_we_i,
  input  logic [REG_W-1:0]   inc_wdata_i,
  output logic [2*REG_W-1:0] time_o,
  output logic [REG_W-1:0]   inc_o
);
  localparam int unsigned TIME_W = 2 * REG_W;
  localparam int unsigned INC_W  = NARROW ? 24 : 31;
  localparam logic [REG_W-1:0] FIELD = REG_W'((64'd1 << INC_W) - 1);
  localparam logic [REG_W-1:0] KEEP  = NARROW ? (FIELD | (REG_W'(1) << INC_W)) : FIELD;

  logic [REG_W-1:0]  inc_q, inc_rst;
  logic [TIME_W-1:0] time_q, step;

  generate
    if (NARROW) begin : g_narrow
      // enable bit sits just above the field; base value pre-shifted
      assign inc_rst = (REG_W'(1) << INC_W) | (REG_W'(INC_BASE_10G >> NARROW_ADJ) & FIELD);
      assign step    = inc_q[INC_W] ? TIME_W'(inc_q & FIELD) : '0;
    end else begin : g_wide
      assign inc_rst = REG_W'(INC_BASE_10G) & FIELD;
      assign step    = TIME_W'(inc_q & FIELD);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q <= inc_rst;
    end else if (inc_we_i) begin
      inc_q <= inc_wdata_i & KEEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
    end else if (load_i) begin
      time_q <= load_val_i;
    end else begin
      time_q <= time_q + step;
    end
  end

  assign time_o = time_q;
  assign inc_o  = inc_q;
endmodule

// File: rtl/ptp_sys_scale.sv
module ptp_sys_scale
  import ptp_sys_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter bit          NARROW = 1'b0
) (
  input  logic [1:0]         link_spd_i,
  input  logic [TIME_W-1:0]  time_i,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [TIME_W-1:0]  ns_o
);
  localparam logic [SHIFT_W-1:0] ADJ = NARROW ? SHIFT_W'(NARROW_ADJ) : '0;

  assign shift_o = base_shift(link_spd_i) - ADJ;
  assign ns_o    = time_i >> shift_o;
endmodule

// File: rtl/ptp_sys_regif.sv
module ptp_sys_regif
  import ptp_sys_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [1:0]         addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [2*REG_W-1:0] time_i,
  input  logic [REG_W-1:0]   inc_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               load_o,
  output logic [2*REG_W-1:0] load_val_o,
  output logic               inc_we_o,
  output logic [REG_W-1:0]   lo_stage_o,
  output logic [REG_W-1:0]   shadow_o,
  output logic [REG_W-1:0]   rdata_o
);
  logic [REG_W-1:0] lo_q, shadow_q, rdata_q, rd_mux;

  assign load_o     = wr_en_i && (addr_i == REG_THI);
  assign load_val_o = {wdata_i, lo_q};
  assign inc_we_o   = wr_en_i && (addr_i == REG_INC);

  always_comb begin
    case (addr_i)
      REG_TLO: rd_mux = time_i[REG_W-1:0];
      REG_THI: rd_mux = shadow_q;
      REG_INC: rd_mux = inc_i;
      default: rd_mux = REG_W'(shift_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      shadow_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_en_i && (addr_i == REG_TLO)) lo_q <= wdata_i;
      if (rd_en_i) begin
        rdata_q <= rd_mux;
        // capture upper half with the low-word read
        if (addr_i == REG_TLO) shadow_q <= time_i[2*REG_W-1:REG_W];
      end
    end
  end

  assign lo_stage_o = lo_q;
  assign shadow_o   = shadow_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/ptp_sys_time.sv
module ptp_sys_time
  import ptp_sys_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter bit          NARROW = 1'b0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [1:0]             addr_i,
  input  logic [REG_W-1:0]       wdata_i,
  input  logic [1:0]             link_spd_i,
  output logic [REG_W-1:0]       rdata_o,
  output logic [2*REG_W-1:0]     time_o,
  output logic [2*REG_W-1:0]     ns_o,
  output logic [SHIFT_W-1:0]     shift_o
);
  localparam int unsigned TIME_W = 2 * REG_W;

  logic              load;
  logic [TIME_W-1:0] load_val;
  logic              inc_we;
  logic [REG_W-1:0]  inc_w, lo_w, shadow_w;
  logic [TIME_W-1:0] time_w;
  logic [SHIFT_W-1:0] shift_w;

  ptp_sys_regif #(.REG_W(REG_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .time_i     (time_w),
    .inc_i      (inc_w),
    .shift_i    (shift_w),
    .load_o     (load),
    .load_val_o (load_val),
    .inc_we_o   (inc_we),
    .lo_stage_o (lo_w),
    .shadow_o   (shadow_w),
    .rdata_o    (rdata_o)
  );

  ptp_sys_accum #(.REG_W(REG_W), .NARROW(NARROW)) u_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_val_i  (load_val),
    .inc_we_i    (inc_we),
    .inc_wdata_i (wdata_i),
    .time_o      (time_w),
    .inc_o       (inc_w)
  );

  ptp_sys_scale #(.TIME_W(TIME_W), .NARROW(NARROW)) u_scale (
    .link_spd_i (link_spd_i),
    .time_i     (time_w),
    .shift_o    (shift_w),
    .ns_o       (ns_o)
  );

  assign time_o  = time_w;
  assign shift_o = shift_w;
endmodule

// File: rtl/ptp_sys_time_chk.sv
module ptp_sys_time_chk
  import ptp_sys_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter bit          NARROW = 1'b0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [1:0]         addr_i,
  input logic [REG_W-1:0]   wdata_i,
  input logic [REG_W-1:0]   rdata_o,
  input logic [2*REG_W-1:0] time_o,
  input logic [SHIFT_W-1:0] shift_o,
  input logic [REG_W-1:0]   inc_w,
  input logic [REG_W-1:0]   lo_w,
  input logic [REG_W-1:0]   shadow_w
);
  localparam int unsigned TIME_W = 2 * REG_W;
  localparam int unsigned INC_W  = NARROW ? 24 : 31;
  localparam int unsigned RSV_LSB = NARROW ? INC_W + 1 : INC_W;
  localparam logic [SHIFT_W-1:0] ADJ = NARROW ? SHIFT_W'(NARROW_ADJ) : '0;

  logic [TIME_W-1:0] exp_step;
  logic              gate;
  assign gate     = NARROW ? inc_w[INC_W] : 1'b1;
  assign exp_step = gate ? TIME_W'(inc_w[INC_W-1:0]) : '0;

  logic hi_wr, lo_rd, hi_rd, inc_wr;
  assign hi_wr  = wr_en_i && (addr_i == REG_THI);
  assign inc_wr = wr_en_i && (addr_i == REG_INC);
  assign lo_rd  = rd_en_i && (addr_i == REG_TLO);
  assign hi_rd  = rd_en_i && (addr_i == REG_THI);

  AST_TIME_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_wr |=> time_o == $past(time_o) + $past(exp_step)); // R2
  AST_HI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr |=> time_o == {$past(wdata_i), $past(lo_w)}); // R6
  AST_LO_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_rd |=> (rdata_o == $past(time_o[REG_W-1:0])) && (shadow_w == $past(time_o[TIME_W-1:REG_W]))); // R5
  AST_HI_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_rd |=> rdata_o == $past(shadow_w)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R5
  AST_INC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_wr |=> $stable(inc_w)); // R3
  AST_INC_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_w >> RSV_LSB) == '0); // R3
  AST_SHIFT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o == 5'd28 - ADJ) || (shift_o == 5'd24 - ADJ) || (shift_o == 5'd21 - ADJ)); // R7
endmodule

bind ptp_sys_time ptp_sys_time_chk #(.REG_W(REG_W), .NARROW(NARROW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .time_o   (time_o),
  .shift_o  (shift_o),
  .inc_w    (inc_w),
  .lo_w     (lo_w),
  .shadow_w (shadow_w)
);

// File: tb/ptp_sys_time_test.sv
`timescale 1ns/1ps
module ptp_sys_time_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [1:0]  spd = 2'd0;

  logic [31:0] rdata_v [2];
  logic [63:0] time_v  [2];
  logic [63:0] ns_v    [2];
  logic [4:0]  shift_v [2];

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ptp_sys_time #(.NARROW(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .link_spd_i(spd), .rdata_o(rdata_v[0]), .time_o(time_v[0]),
    .ns_o(ns_v[0]), .shift_o(shift_v[0]));

  ptp_sys_time #(.NARROW(1'b1)) uut_n (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .link_spd_i(spd), .rdata_o(rdata_v[1]), .time_o(time_v[1]),
    .ns_o(ns_v[1]), .shift_o(shift_v[1]));

  // reference model state, index 0 wide, 1 narrow
  logic [63:0] m_t  [2];
  logic [31:0] m_inc[2];
  logic [31:0] m_lo [2];
  logic [31:0] m_sh [2];
  logic [31:0] m_rd [2];

  function automatic logic [4:0] ref_shift(int v, logic [1:0] s);
    int b;
    b = (s == 2'd1) ? 24 : (s == 2'd2) ? 21 : 28;
    if (v == 1) b = b - 7;
    return 5'(b);
  endfunction

  function automatic logic [31:0] ref_keep(int v, logic [31:0] d);
    return (v == 1) ? (d & 32'h01FF_FFFF) : (d & 32'h7FFF_FFFF);
  endfunction

  function automatic logic [63:0] ref_adv(int v);
    if (v == 1) return m_inc[1][24] ? {40'd0, m_inc[1][23:0]} : 64'd0;
    return {33'd0, m_inc[0][30:0]};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int v = 0; v < 2; v++) begin
      m_t[v] = '0; m_lo[v] = '0; m_sh[v] = '0; m_rd[v] = '0;
    end
    m_inc[0] = 32'h6666_6666;
    m_inc[1] = 32'h01CC_CCCC;
  endtask

  task automatic step(bit w, bit r, logic [1:0] a, logic [31:0] d);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk);
    for (int v = 0; v < 2; v++) begin
      logic [63:0] old_t;
      old_t = m_t[v];
      if (r) begin
        case (a)
          2'd0: begin m_rd[v] = old_t[31:0]; m_sh[v] = old_t[63:32]; end
          2'd1: m_rd[v] = m_sh[v];
          2'd2: m_rd[v] = m_inc[v];
          default: m_rd[v] = {27'd0, ref_shift(v, spd)};
        endcase
      end
      if (w && a == 2'd1) m_t[v] = {d, m_lo[v]};
      else                m_t[v] = old_t + ref_adv(v);
      if (w && a == 2'd0) m_lo[v] = d;
      if (w && a == 2'd2) m_inc[v] = ref_keep(v, d);
    end
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      chk("R2", "time", time_v[v], m_t[v]);
      chk("R7", "ns", ns_v[v], m_t[v] >> ref_shift(v, spd));
      chk("R5", "rdata", {32'd0, rdata_v[v]}, {32'd0, m_rd[v]});
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] keep_t;
    model_reset();
    repeat (3) @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      chk("R1", "time in reset", time_v[v], 64'd0);
      chk("R1", "rdata in reset", {32'd0, rdata_v[v]}, 64'd0);
    end
    rst_n = 1'b1;
    idle(5);

    // R1: default increment per variant
    step(1'b0, 1'b1, 2'd2, 32'd0);
    chk("R1", "wide inc", {32'd0, rdata_v[0]}, 64'h6666_6666);
    chk("R1", "narrow inc", {32'd0, rdata_v[1]}, 64'h01CC_CCCC);

    // R5: coherent pair read with time moving in between
    keep_t = m_t[0];
    step(1'b0, 1'b1, 2'd0, 32'd0);
    idle(3);
    step(1'b0, 1'b1, 2'd1, 32'd0);
    chk("R5", "hi from shadow", {32'd0, rdata_v[0]}, {32'd0, keep_t[63:32]});

    // R3 and R4: upper bits dropped; narrow enable bit cleared halts time
    step(1'b1, 1'b0, 2'd2, 32'h8000_0010);
    step(1'b0, 1'b1, 2'd2, 32'd0);
    chk("R3", "wide masked", {32'd0, rdata_v[0]}, 64'h0000_0010);
    chk("R3", "narrow masked", {32'd0, rdata_v[1]}, 64'h0000_0010);
    keep_t = time_v[1];
    idle(4);
    chk("R4", "narrow halted", time_v[1], keep_t);

    step(1'b1, 1'b0, 2'd2, 32'h0100_0100);
    chk("R3", "write edge uses old inc", time_v[1], keep_t);
    idle(2);

    // R6: staged low then atomic high load, R9 wrap
    step(1'b1, 1'b0, 2'd0, 32'hFFFF_FF00);
    chk("R6", "low write only stages", time_v[1], keep_t + 64'h300);
    step(1'b1, 1'b0, 2'd1, 32'hFFFF_FFFF);
    chk("R6", "wide loaded", time_v[0], 64'hFFFF_FFFF_FFFF_FF00);
    chk("R6", "narrow loaded", time_v[1], 64'hFFFF_FFFF_FFFF_FF00);
    idle(1);
    chk("R9", "wide wrapped", time_v[0], 64'h0000_0000_0100_0000);
    chk("R9", "narrow wrapped", time_v[1], 64'd0);
    idle(3);

    // R8: status address is read only
    keep_t = m_t[0];
    step(1'b1, 1'b0, 2'd3, 32'hFFFF_FFFF);
    chk("R8", "time unaffected", time_v[0], keep_t + 64'h0100_0100);
    step(1'b0, 1'b1, 2'd2, 32'd0);
    chk("R8", "inc unaffected", {32'd0, rdata_v[0]}, 64'h0100_0100);
    step(1'b1, 1'b0, 2'd1, 32'h0000_0001);
    chk("R8", "staged word unaffected", time_v[0], 64'h0000_0001_FFFF_FF00);

    // R7: shift per link code
    for (int s = 0; s < 4; s++) begin
      spd = 2'(s);
      step(1'b0, 1'b1, 2'd3, 32'd0);
      chk("R7", "wide shift", {59'd0, shift_v[0]}, {59'd0, ref_shift(0, spd)});
      chk("R7", "narrow shift", {32'd0, rdata_v[1]}, {59'd0, ref_shift(1, spd)});
    end
    spd = 2'd0;

    step(1'b1, 1'b0, 2'd2, 32'h6666_6666);
    idle(20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule